// File: doc/BRIEF.md
# Byte-Lane Flash Command Decoder

This block models the command side of one byte-wide flash lane in synthesizable logic. A host writes through a plain address, data and write-strobe port. The block recognises the unlock-and-command sequences that start a byte program, a full erase or an erase of selected sectors. It then runs the operation on a small register array for a number of clock cycles set by a parameter.

While an operation runs, reads do not return array contents. They return a status byte: a polling bit that carries the complement of the bit 7 value being written, and a bit that changes on every read. An erase can be put on hold. While it is held, sectors outside the erase set can be read and programmed. A resume command restarts the erase from where it stopped.

A power-on reset fills the array with ones, which is the erased state. A separate device reset input stops any operation and returns the decoder to reading, and it leaves the array as it is. The array holds SECTORS × SEC_BYTES bytes. The array index is the low address bits, and the sector number is the top bits of that index.

Top module: `flashcmd`

## Requirements
- R1: After power-on reset every array byte reads 8'hFF, `busy` is low, and a read returns its byte on `rdata` one clock after the cycle in which `rd_en` is high.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then (PA, PD) program the byte at index PA; the stored value becomes old AND PD, so programming only clears bits.
- R3: After the last program write, `busy` stays high for exactly PROG_CYC cycles.
- R4: While `busy` is high, a read returns the status byte {p, t, 6'b0}. During a program p is the inverse of PD bit 7, and during an erase p is 0. Once the operation ends, reads return the true data.
- R5: Status bit t (bit 6) flips on each successive status read and is 0 at the first one after power-on.
- R6: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h erase every byte to FFh, with `busy` high for ERASE_CYC cycles.
- R7: Ending the erase sequence with 30h at a sector address selects that sector. Each further 30h write within SEL_CYC cycles adds a sector and restarts the window. `busy` then stays high for SEL_CYC+ERASE_CYC cycles after the last 30h, and only the selected sectors become FFh.
- R8: A write with the wrong address or the wrong data inside a command sequence returns the decoder to reading, and the array is not changed.
- R9: Writing B0h during a running erase suspends it. `busy` drops, reads of sectors outside the erase set return array data, and reads of sectors inside it return the status byte with p=0.
- R10: While suspended, a program sequence aimed at a sector outside the erase set programs normally. One aimed at a sector inside the set is dropped, and `busy` stays low.
- R11: Writing 30h while suspended resumes the erase. Cycles run before the suspension count toward ERASE_CYC, so `busy` stays high for fewer than ERASE_CYC cycles afterwards.
- R12: A cycle with `dev_reset_n` low stops any program or erase without changing the array, clears any suspension, and leaves `busy` low.
- R13: Writes during a running program, including B0h, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset; fills the array with ones |
| dev_reset_n | input | 1 | Synchronous active-low device reset; stops operations, keeps the array |
| wr_en | input | 1 | Write strobe, one write per cycle in which it is high |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte address for commands, programs and reads |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Read data or status byte, registered |
| busy | output | 1 | High while a program, sector-select window or erase is running |

## Verification
The assertions check the following on every cycle:
- Programming a byte never sets a bit.
- No operation counter passes its limit.
- A program stays in progress until its timer ends or a device reset arrives.
- A suspension always has at least one sector in its erase set.
- Polling reads during a program carry the inverted bit 7.
- Back-to-back status reads alternate bit 6.
- A device reset always leaves `busy` low.

Some properties depend on the array contents over a whole sequence, so only the bench scenarios can show them. These are the exact busy lengths, which sectors are erased, that broken sequences and commands dropped during suspension leave data unchanged, and that a resumed erase keeps the time it had already spent.

// File: rtl/flashcmd_pkg.sv
package flashcmd_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PA, ST_E3, ST_E4, ST_E5, ST_ESEL, ST_PROG, ST_ERASE
  } cmd_state_e;

  localparam logic [10:0] UNLOCK_A = 11'h555;
  localparam logic [10:0] UNLOCK_B = 11'h2AA;
  localparam logic [7:0]  CD_KEY1  = 8'hAA;
  localparam logic [7:0]  CD_KEY2  = 8'h55;
  localparam logic [7:0]  CD_PROG  = 8'hA0;
  localparam logic [7:0]  CD_ERASE = 8'h80;
  localparam logic [7:0]  CD_CHIP  = 8'h10;
  localparam logic [7:0]  CD_SECT  = 8'h30;
  localparam logic [7:0]  CD_SUSP  = 8'hB0;
endpackage

// File: rtl/flashcmd_timer.sv
module flashcmd_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             run,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (run) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done = run && !clr && (cnt_q == limit - 1'b1);

  // R3: a running count never reaches its limit before it completes
  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q < limit));
endmodule

// File: rtl/flashcmd_array.sv
module flashcmd_array #(
  parameter int SECTORS   = 16,
  parameter int SEC_BYTES = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   pgm_en,
  input  logic [$clog2(SECTORS*SEC_BYTES)-1:0]   pgm_idx,
  input  logic [7:0]                             pgm_data,
  input  logic                                   ers_en,
  input  logic [SECTORS-1:0]                     ers_mask,
  input  logic [$clog2(SECTORS*SEC_BYTES)-1:0]   rd_idx,
  output logic [7:0]                             rd_data
);
  localparam int DEPTH = SECTORS * SEC_BYTES;
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH*8-1:0] mem_flat;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic [7:0] byte_q;
    logic       sel_pgm, sel_ers;
    assign sel_pgm = pgm_en && (pgm_idx == IDX_W'(g));
    assign sel_ers = ers_en && ers_mask[g / SEC_BYTES];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       byte_q <= 8'hFF;
      else if (sel_ers) byte_q <= 8'hFF;
      else if (sel_pgm) byte_q <= byte_q & pgm_data;
    end
    assign mem_flat[g*8 +: 8] = byte_q;

    // R2: programming only clears bits
    assert_pgm_clears_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sel_pgm |=> ((byte_q & ~$past(byte_q)) == 8'h00));
  end

  assign rd_data = mem_flat[rd_idx*8 +: 8];

  // R6: program and erase completion never coincide
  assert_single_op_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_en && ers_en));
endmodule

// File: rtl/flashcmd_seq.sv
module flashcmd_seq
  import flashcmd_pkg::*;
#(
  parameter int ADDR_W  = 11,
  parameter int SECTORS = 16,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               dev_reset_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [7:0]         wdata,
  input  logic               op_done_i,
  input  logic               ers_done_i,
  output logic               busy_o,
  output logic               prog_o,
  output logic               susp_o,
  output logic [SECTORS-1:0] mask_o,
  output logic [IDX_W-1:0]   pa_o,
  output logic [7:0]         pd_o,
  output logic               pgm_fire_o,
  output logic               ers_fire_o,
  output logic               op_clr_o,
  output logic               op_run_o,
  output logic               op_win_o,
  output logic               ers_clr_o,
  output logic               ers_run_o
);
  localparam int SEC_W = $clog2(SECTORS);

  cmd_state_e         state_q, state_d;
  logic               susp_q, susp_d;
  logic [SECTORS-1:0] mask_q, mask_d, wr_hot;
  logic [IDX_W-1:0]   pa_q, pa_d;
  logic [7:0]         pd_q, pd_d;
  logic [SEC_W-1:0]   wr_sec;
  logic               key1, key2, at_a;

  assign at_a   = (addr[10:0] == UNLOCK_A);
  assign key1   = at_a && (wdata == CD_KEY1);
  assign key2   = (addr[10:0] == UNLOCK_B) && (wdata == CD_KEY2);
  assign wr_sec = addr[IDX_W-1 -: SEC_W];
  assign wr_hot = {{(SECTORS-1){1'b0}}, 1'b1} << wr_sec;

  always_comb begin
    state_d = state_q; susp_d = susp_q; mask_d = mask_q;
    pa_d = pa_q; pd_d = pd_q;
    pgm_fire_o = 1'b0; ers_fire_o = 1'b0; op_clr_o = 1'b0; ers_clr_o = 1'b0;
    case (state_q)
      ST_READ: if (wr_en) begin
        if (susp_q && wdata == CD_SECT) begin state_d = ST_ERASE; susp_d = 1'b0; end
        else if (key1) state_d = ST_U1;
      end
      ST_U1: if (wr_en) state_d = key2 ? ST_U2 : ST_READ;
      ST_U2: if (wr_en) begin
        if (at_a && wdata == CD_PROG)                 state_d = ST_PA;
        else if (at_a && wdata == CD_ERASE && !susp_q) state_d = ST_E3;
        else                                          state_d = ST_READ;
      end
      ST_PA: if (wr_en) begin
        pa_d = addr[IDX_W-1:0];
        pd_d = wdata;
        if (susp_q && mask_q[wr_sec]) state_d = ST_READ;
        else begin state_d = ST_PROG; op_clr_o = 1'b1; end
      end
      ST_E3: if (wr_en) state_d = key1 ? ST_E4 : ST_READ;
      ST_E4: if (wr_en) state_d = key2 ? ST_E5 : ST_READ;
      ST_E5: if (wr_en) begin
        if (at_a && wdata == CD_CHIP) begin
          mask_d = '1; state_d = ST_ERASE; ers_clr_o = 1'b1;
        end else if (wdata == CD_SECT) begin
          mask_d = wr_hot; state_d = ST_ESEL; op_clr_o = 1'b1; ers_clr_o = 1'b1;
        end else state_d = ST_READ;
      end
      ST_ESEL: begin
        if (wr_en) begin
          if (wdata == CD_SECT) begin mask_d = mask_q | wr_hot; op_clr_o = 1'b1; end
          else begin state_d = ST_READ; mask_d = '0; end
        end else if (op_done_i) state_d = ST_ERASE;
      end
      ST_PROG: if (op_done_i) begin pgm_fire_o = 1'b1; state_d = ST_READ; end
      ST_ERASE: begin
        if (ers_done_i) begin ers_fire_o = 1'b1; state_d = ST_READ; mask_d = '0; end
        else if (wr_en && wdata == CD_SUSP) begin state_d = ST_READ; susp_d = 1'b1; end
      end
      default: state_d = ST_READ;
    endcase
    if (!dev_reset_n) begin
      state_d = ST_READ; susp_d = 1'b0; mask_d = '0;
      op_clr_o = 1'b1; ers_clr_o = 1'b1; pgm_fire_o = 1'b0; ers_fire_o = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_READ; susp_q <= 1'b0; mask_q <= '0; pa_q <= '0; pd_q <= '0;
    end else begin
      state_q <= state_d; susp_q <= susp_d; mask_q <= mask_d; pa_q <= pa_d; pd_q <= pd_d;
    end
  end

  assign prog_o    = (state_q == ST_PROG);
  assign busy_o    = prog_o || (state_q == ST_ESEL) || (state_q == ST_ERASE);
  assign susp_o    = susp_q;
  assign mask_o    = mask_q;
  assign pa_o      = pa_q;
  assign pd_o      = pd_q;
  assign op_run_o  = prog_o || (state_q == ST_ESEL);
  assign op_win_o  = (state_q == ST_ESEL);
  assign ers_run_o = (state_q == ST_ERASE);

  // R9: a suspended erase always holds at least one selected sector
  assert_susp_has_sectors_R9: assert property (@(posedge clk) disable iff (!rst_n)
    susp_q |-> (mask_q != '0));

  // R3, R13: a program leaves only through its timer or a device reset
  assert_prog_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    prog_o |=> (prog_o || $past(op_done_i) || !$past(dev_reset_n)));
endmodule

// File: rtl/flashcmd.sv
module flashcmd #(
  parameter int ADDR_W    = 11,
  parameter int SECTORS   = 16,
  parameter int SEC_BYTES = 4,
  parameter int PROG_CYC  = 8,
  parameter int SEL_CYC   = 6,
  parameter int ERASE_CYC = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dev_reset_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              busy
);
  localparam int DEPTH = SECTORS * SEC_BYTES;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int SEC_W = $clog2(SECTORS);
  localparam int MAX_A = (PROG_CYC > SEL_CYC) ? PROG_CYC : SEL_CYC;
  localparam int MAX_C = (MAX_A > ERASE_CYC) ? MAX_A : ERASE_CYC;
  localparam int CNT_W = $clog2(MAX_C + 1);

  logic               prog, susp, pgm_fire, ers_fire;
  logic               op_clr, op_run, op_win, op_done, ers_clr, ers_run, ers_done;
  logic [SECTORS-1:0] mask;
  logic [IDX_W-1:0]   pa;
  logic [7:0]         pd, arr_rd, stat, rdata_q, rdata_d;
  logic [CNT_W-1:0]   op_lim;
  logic               tog_q, tog_d, stat_sel;
  logic [SEC_W-1:0]   rd_sec;

  flashcmd_seq #(.ADDR_W(ADDR_W), .SECTORS(SECTORS), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .dev_reset_n(dev_reset_n), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .op_done_i(op_done), .ers_done_i(ers_done),
    .busy_o(busy), .prog_o(prog), .susp_o(susp), .mask_o(mask), .pa_o(pa),
    .pd_o(pd), .pgm_fire_o(pgm_fire), .ers_fire_o(ers_fire), .op_clr_o(op_clr),
    .op_run_o(op_run), .op_win_o(op_win), .ers_clr_o(ers_clr), .ers_run_o(ers_run));

  assign op_lim = op_win ? CNT_W'(SEL_CYC) : CNT_W'(PROG_CYC);

  flashcmd_timer #(.CNT_W(CNT_W)) u_op_tmr (
    .clk(clk), .rst_n(rst_n), .clr(op_clr), .run(op_run), .limit(op_lim), .done(op_done));

  flashcmd_timer #(.CNT_W(CNT_W)) u_ers_tmr (
    .clk(clk), .rst_n(rst_n), .clr(ers_clr), .run(ers_run),
    .limit(CNT_W'(ERASE_CYC)), .done(ers_done));

  flashcmd_array #(.SECTORS(SECTORS), .SEC_BYTES(SEC_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .pgm_en(pgm_fire), .pgm_idx(pa), .pgm_data(pd),
    .ers_en(ers_fire), .ers_mask(mask), .rd_idx(addr[IDX_W-1:0]), .rd_data(arr_rd));

  assign rd_sec   = addr[IDX_W-1 -: SEC_W];
  assign stat_sel = busy || (susp && mask[rd_sec]);
  assign stat     = {prog ? ~pd[7] : 1'b0, tog_q, 6'b0};

  always_comb begin
    rdata_d = rdata_q;
    tog_d   = tog_q;
    if (rd_en) begin
      rdata_d = stat_sel ? stat : arr_rd;
      if (stat_sel) tog_d = ~tog_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rdata_q <= '0; tog_q <= 1'b0; end
    else        begin rdata_q <= rdata_d; tog_q <= tog_d; end
  end

  assign rdata = rdata_q;

  // R4: a polling read during a program shows inverted bit 7
  assert_poll_bit7_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && prog) |=> (rdata_q[7] != $past(pd[7])));

  // R5: back-to-back status reads alternate bit 6
  assert_toggle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && stat_sel && $past(rd_en && stat_sel)) |=> (rdata_q[6] != $past(rdata_q[6])));

  // R12: device reset always lands in reading with busy low
  assert_abort_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !dev_reset_n |=> !busy);
endmodule

// File: tb/flashcmd_tb.sv
module flashcmd_tb;
  localparam int PROG_CYC = 8, SEL_CYC = 6, ERASE_CYC = 40;

  logic clk = 1'b0, rst_n = 1'b0, dev_reset_n = 1'b1, wr_en = 1'b0, rd_en = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0, rdata;
  logic        busy;

  logic [7:0] mdl [64];
  logic       exp_tog = 1'b0;
  int checks = 0, fails = 0;
  bit finished = 0;

  flashcmd #(.PROG_CYC(PROG_CYC), .SEL_CYC(SEL_CYC), .ERASE_CYC(ERASE_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .dev_reset_n(dev_reset_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .busy(busy));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [10:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [10:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [10:0] a);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, mdl[a[5:0]]);
  endtask

  task automatic rd_stat(input string req, input logic [10:0] a, input logic p);
    logic [7:0] v;
    rd(a, v);
    chk(req, v, {p, exp_tog, 6'b0});
    exp_tog = ~exp_tog;
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask

  task automatic prog_seq(input logic [10:0] a, input logic [7:0] d);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'hA0); wr(a, d);
  endtask

  task automatic erase_head();
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55); wr(11'h555, 8'h80);
    wr(11'h555, 8'hAA); wr(11'h2AA, 8'h55);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    logic [10:0] a;
    logic [7:0]  d, v;
    void'($urandom(32'h5EED));
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 busy", {7'b0, busy}, 8'h00);
    for (int i = 0; i < 64; i += 9) rd_chk("R1 erased after reset", 11'(i));

    // random mix: programs, reads, broken sequences
    for (int it = 0; it < 150; it++) begin
      a = 11'($urandom) & 11'h7FF;
      d = 8'($urandom);
      case ($urandom % 3)
        0: begin
          prog_seq(a, d);
          busy_len(n);
          chk("R3 program busy length", 8'(n), 8'(PROG_CYC));
          mdl[a[5:0]] = mdl[a[5:0]] & d;
          rd_chk("R2 program result", a);
        end
        1: rd_chk("R2 random read", a);
        default: begin
          wr(11'h555, 8'hAA); wr(11'h2AA, 8'h54);
          wr(a, d & 8'h7F);
          chk("R8 no busy after broken unlock", {7'b0, busy}, 8'h00);
          rd_chk("R8 array unchanged", a);
        end
      endcase
    end

    // R4 / R5: polling and toggle during a program
    prog_seq(11'h005, 8'h35);
    rd_stat("R4 poll bit7 first read", 11'h005, 1'b1);
    rd_stat("R5 toggle second read", 11'h005, 1'b1);
    busy_len(n);
    mdl[5] = mdl[5] & 8'h35;
    rd_chk("R4 true data after program", 11'h005);
    rd_chk("R5 no toggle once idle", 11'h005);

    // R13: writes during a program are ignored
    prog_seq(11'h006, 8'hF0);
    wr(11'h000, 8'hB0);
    chk("R13 busy kept through B0", {7'b0, busy}, 8'h01);
    busy_len(n);
    mdl[6] = mdl[6] & 8'hF0;
    rd_chk("R13 program completes", 11'h006);

    // R6: chip erase
    erase_head(); wr(11'h555, 8'h10);
    rd_stat("R4 erase poll bit7 zero", 11'h010, 1'b0);
    busy_len(n);
    chk("R6 chip erase busy length", 8'(n + 2), 8'(ERASE_CYC));
    for (int i = 0; i < 64; i++) mdl[i] = 8'hFF;
    for (int i = 0; i < 64; i += 5) rd_chk("R6 all erased", 11'(i));

    // R7: multi-sector erase
    prog_seq(11'h008, 8'h00); busy_len(n); mdl[8]  = 8'h00;
    prog_seq(11'h01C, 8'h00); busy_len(n); mdl[28] = 8'h00;
    prog_seq(11'h024, 8'h00); busy_len(n); mdl[36] = 8'h00;
    erase_head(); wr(11'h008, 8'h30); wr(11'h024, 8'h30);
    busy_len(n);
    chk("R7 sector erase busy length", 8'(n), 8'(SEL_CYC + ERASE_CYC));
    mdl[8] = 8'hFF; mdl[36] = 8'hFF;
    rd_chk("R7 sector 2 erased", 11'h008);
    rd_chk("R7 sector 9 erased", 11'h024);
    rd_chk("R7 sector 7 kept", 11'h01C);

    // R8: broken erase sequence
    erase_head(); wr(11'h555, 8'h20);
    chk("R8 no erase started", {7'b0, busy}, 8'h00);
    rd_chk("R8 data kept", 11'h01C);

    // R9 / R10 / R11: suspend and resume
    prog_seq(11'h00C, 8'h11); busy_len(n); mdl[12] = 8'h11;
    prog_seq(11'h028, 8'h22); busy_len(n); mdl[40] = 8'h22;
    erase_head(); wr(11'h00C, 8'h30);
    repeat (20) @(negedge clk);
    wr(11'h000, 8'hB0);
    chk("R9 busy low when suspended", {7'b0, busy}, 8'h00);
    rd_chk("R9 read outside erase set", 11'h028);
    rd_stat("R9 status inside erase set", 11'h00C, 1'b0);
    prog_seq(11'h029, 8'h0F); busy_len(n);
    chk("R10 suspended program length", 8'(n), 8'(PROG_CYC));
    mdl[41] = 8'h0F;
    rd_chk("R10 suspended program data", 11'h029);
    prog_seq(11'h00D, 8'h00);
    chk("R10 program in erase set dropped", {7'b0, busy}, 8'h00);
    wr(11'h000, 8'h30);
    busy_len(n);
    chk("R11 resumed time shorter", {7'b0, (n > 0 && n < ERASE_CYC)}, 8'h01);
    mdl[12] = 8'hFF;
    rd_chk("R11 erase finished", 11'h00C);
    rd_chk("R11 neighbour kept", 11'h028);

    // R12: device reset aborts a program, then a suspended erase
    prog_seq(11'h032, 8'h00);
    @(negedge clk); dev_reset_n = 1'b0;
    @(negedge clk); dev_reset_n = 1'b1;
    chk("R12 busy low after abort", {7'b0, busy}, 8'h00);
    rd_chk("R12 aborted program left data", 11'h032);
    prog_seq(11'h010, 8'h44); busy_len(n); mdl[16] = 8'h44;
    erase_head(); wr(11'h010, 8'h30);
    repeat (12) @(negedge clk);
    wr(11'h000, 8'hB0);
    @(negedge clk); dev_reset_n = 1'b0;
    @(negedge clk); dev_reset_n = 1'b1;
    wr(11'h000, 8'h30);
    chk("R12 no resume after reset", {7'b0, busy}, 8'h00);
    rd_chk("R12 suspended sector kept", 11'h010);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule